// File: doc/BRIEF.md
# Single-Channel Dual-Address DMA Transfer Engine

This block is the datapath and sequencer of one DMA channel. A channel is first programmed with a source address, a destination address, a transfer count, a unit size and an address-update mode for each side. It is then armed. Each request moves exactly one data unit: the engine reads one byte or halfword from the source, writes it to the destination, and then drops its bus request so that other masters can use the bus before the next unit.

Addresses are 24 bits wide. The upper 8 bits select a 64 KB bank that never changes during a block. Each side can stay fixed, step forward by the unit size, or step through a ring of 2, 4, 8, 16 or 32 units and then jump back to the address it was programmed with. The count register holds the number of units minus one and counts down once per completed write. The write that takes it below zero ends the block: it pulses an end-of-block output and disarms the channel.

Top module: `dma_xfer_engine`

## Requirements
- R1: While reset is applied and after it is released, `chan_en`, `bus_req`, `xfer_done` and `block_end` are all 0.
- R2: An accepted request produces one bus read at the source address and then one bus write to the destination address, carrying the data that was read. `bus_req` then goes low before any further access.
- R3: `cfg_unit` = 0 selects 8-bit units, which travel on data bits [7:0] with bits [15:8] written as zero and `bus_half` = 0. `cfg_unit` = 1 selects 16-bit units, which travel intact on [15:0] with `bus_half` = 1 at an even address. The bus is little-endian: the lower byte is at the even address.
- R4: Mode code 00 (fixed) keeps that side's address unchanged for every transfer. Code 11 behaves the same way.
- R5: Mode code 01 (increment) advances that side's address by 1 per 8-bit transfer and by 2 per 16-bit transfer.
- R6: Mode code 10 (ring) advances like increment mode. After 2^(sel+1) transfers the address returns to its programmed start. The ring select field `sel` takes values 0 to 4, and values above 4 act as 4.
- R7: Address stepping wraps within bits [15:0], and bits [23:16] never change.
- R8: `cfg_count` is loaded with N-1 for a block of N transfers. `block_end` is a one-cycle pulse that coincides with the `xfer_done` of the Nth transfer, and with no earlier one.
- R9: `cfg_load` arms the channel (`chan_en` = 1), and it is ignored while a transfer is in progress. Requests made while the channel is not armed cause no bus activity. The hardware clears `chan_en` when the block ends.
- R10: A request that arrives while a transfer is in progress is dropped. It causes no additional transfer.
- R11: `xfer_done` is high for exactly one cycle, in the cycle after each write is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load the channel configuration and arm the channel |
| cfg_src_addr | input | 24 | Source start address |
| cfg_dst_addr | input | 24 | Destination start address |
| cfg_count | input | 16 | Number of transfers minus one |
| cfg_unit | input | 1 | 0 = 8-bit unit, 1 = 16-bit unit |
| cfg_src_mode | input | 2 | Source address mode (00 fixed, 01 increment, 10 ring) |
| cfg_dst_mode | input | 2 | Destination address mode |
| cfg_src_ring | input | 3 | Source ring select, ring length 2^(sel+1) units |
| cfg_dst_ring | input | 3 | Destination ring select |
| xfer_req | input | 1 | Request for one transfer |
| chan_en | output | 1 | Channel armed |
| xfer_done | output | 1 | One-cycle pulse after each completed transfer |
| block_end | output | 1 | One-cycle pulse when the count underflows |
| bus_req | output | 1 | Bus access request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_half | output | 1 | 1 = 16-bit access, 0 = 8-bit access |
| bus_addr | output | 24 | Bus byte address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid while bus_ack is high |
| bus_ack | input | 1 | Access acknowledge |

## Verification
The bench drives a ring that starts at an unaligned odd address. A design that masked low address bits instead of reloading the start would jump to the wrong place on the wrap. A halfword source is placed just below a bank's top, where carrying into bits [23:16] would move the access to another bank. A single-transfer block loaded with count 0 catches an end-of-block signal that comes one transfer late or not at all. The bench also issues requests while the channel is disarmed and while a transfer is in flight. A design that queued or honoured either would produce extra bus reads.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

  typedef enum logic [1:0] {
    AM_FIXED = 2'b00,
    AM_INC   = 2'b01,
    AM_RING  = 2'b10,
    AM_HOLD  = 2'b11
  } addr_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'b00,
    SQ_READ  = 2'b01,
    SQ_WRITE = 2'b10
  } seq_state_e;

endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int OFS_W    = 16,
  parameter int RING_LOG = 5,
  parameter int RSEL_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [1:0]        load_mode,
  input  logic [RSEL_W-1:0] load_rsel,
  input  logic              half,
  input  logic              advance,
  output logic [ADDR_W-1:0] cur_addr
);

  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [ADDR_W-1:0]   start_q, start_d;
  logic [1:0]          mode_q, mode_d;
  logic [RSEL_W-1:0]   rsel_q, rsel_d;
  logic [RING_LOG-1:0] rcnt_q, rcnt_d;
  logic [RING_LOG-1:0] ring_last;
  logic [OFS_W-1:0]    step;
  logic [OFS_W-1:0]    ofs_next;
  logic [ADDR_W-1:0]   stepped;
  logic                upd;

  // the last ring index is 2^(sel+1)-1, and a select beyond the range saturates
  always_comb begin
    if (int'(rsel_q) >= RING_LOG - 1) begin
      ring_last = {RING_LOG{1'b1}};
    end else begin
      ring_last = {RING_LOG{1'b1}} >> (RING_LOG - 1 - int'(rsel_q));
    end
  end

  assign step     = half ? OFS_W'(2) : OFS_W'(1);
  assign ofs_next = addr_q[OFS_W-1:0] + step;
  // the bank bits are carried over unchanged and only the offset wraps
  assign stepped  = {addr_q[ADDR_W-1:OFS_W], ofs_next};
  assign upd      = load | advance;

  always_comb begin
    addr_d  = addr_q;
    start_d = start_q;
    mode_d  = mode_q;
    rsel_d  = rsel_q;
    rcnt_d  = rcnt_q;
    if (load) begin
      addr_d  = load_addr;
      start_d = load_addr;
      mode_d  = load_mode;
      rsel_d  = load_rsel;
      rcnt_d  = '0;
    end else if (advance) begin
      case (mode_q)
        AM_INC: addr_d = stepped;
        AM_RING: begin
          if (rcnt_q == ring_last) begin
            addr_d = start_q;
            rcnt_d = '0;
          end else begin
            addr_d = stepped;
            rcnt_d = rcnt_q + 1'b1;
          end
        end
        default: addr_d = addr_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      start_q <= '0;
      mode_q  <= AM_FIXED;
      rsel_q  <= '0;
      rcnt_q  <= '0;
    end else if (upd) begin
      addr_q  <= addr_d;
      start_q <= start_d;
      mode_q  <= mode_d;
      rsel_q  <= rsel_d;
      rcnt_q  <= rcnt_d;
    end
  end

  assign cur_addr = addr_q;

endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             underflow
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd;

  assign upd = load | dec;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (dec) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (upd) begin
      cnt_q <= cnt_d;
    end
  end

  // the block ends when a decrement is applied to a count of zero
  assign underflow = dec && (cnt_q == '0);

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_eng_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic bus_ack,
  output logic idle,
  output logic rd_phase,
  output logic wr_phase,
  output logic capture,
  output logic step
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      SQ_IDLE:  if (start)   state_d = SQ_READ;
      SQ_READ:  if (bus_ack) state_d = SQ_WRITE;
      SQ_WRITE: if (bus_ack) state_d = SQ_IDLE;
      default:               state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign idle     = (state_q == SQ_IDLE);
  assign rd_phase = (state_q == SQ_READ);
  assign wr_phase = (state_q == SQ_WRITE);
  assign capture  = rd_phase && bus_ack;
  assign step     = wr_phase && bus_ack;

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine #(
  parameter int ADDR_W   = 24,
  parameter int OFS_W    = 16,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 16,
  parameter int RING_LOG = 5,
  parameter int RSEL_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_src_addr,
  input  logic [ADDR_W-1:0] cfg_dst_addr,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              cfg_unit,
  input  logic [1:0]        cfg_src_mode,
  input  logic [1:0]        cfg_dst_mode,
  input  logic [RSEL_W-1:0] cfg_src_ring,
  input  logic [RSEL_W-1:0] cfg_dst_ring,
  input  logic              xfer_req,
  output logic              chan_en,
  output logic              xfer_done,
  output logic              block_end,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_half,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack
);

  localparam int BYTE_W = DATA_W / 2;
  localparam int NSIDE  = 2;

  // reset is asserted at once and released through two flops
  logic rst_s1_q, rst_s2_q, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_i = rst_s2_q;

  logic idle, rd_phase, wr_phase, capture, step;
  logic load_ok, start, underflow;
  logic en_q, en_d, en_upd;
  logic half_q;
  logic [DATA_W-1:0] data_q, data_d;
  logic done_q, eob_q;

  logic [NSIDE-1:0][ADDR_W-1:0] side_start;
  logic [NSIDE-1:0][1:0]        side_mode;
  logic [NSIDE-1:0][RSEL_W-1:0] side_rsel;
  logic [NSIDE-1:0][ADDR_W-1:0] side_addr;

  assign load_ok = cfg_load && idle;
  assign start   = xfer_req && en_q;

  dma_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_i),
    .start    (start),
    .bus_ack  (bus_ack),
    .idle     (idle),
    .rd_phase (rd_phase),
    .wr_phase (wr_phase),
    .capture  (capture),
    .step     (step)
  );

  // side 0 is the source, side 1 the destination
  assign side_start[0] = cfg_src_addr;
  assign side_start[1] = cfg_dst_addr;
  assign side_mode[0]  = cfg_src_mode;
  assign side_mode[1]  = cfg_dst_mode;
  assign side_rsel[0]  = cfg_src_ring;
  assign side_rsel[1]  = cfg_dst_ring;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dma_addr_unit #(
      .ADDR_W   (ADDR_W),
      .OFS_W    (OFS_W),
      .RING_LOG (RING_LOG),
      .RSEL_W   (RSEL_W)
    ) u_addr (
      .clk       (clk),
      .rst_n     (rst_i),
      .load      (load_ok),
      .load_addr (side_start[g]),
      .load_mode (side_mode[g]),
      .load_rsel (side_rsel[g]),
      .half      (half_q),
      .advance   (step),
      .cur_addr  (side_addr[g])
    );
  end

  dma_count_unit #(.CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_i),
    .load      (load_ok),
    .load_val  (cfg_count),
    .dec       (step),
    .underflow (underflow)
  );

  always_comb begin
    en_d = en_q;
    if (load_ok) begin
      en_d = 1'b1;
    end else if (underflow) begin
      en_d = 1'b0;
    end
  end
  assign en_upd = load_ok | underflow;

  always_comb begin
    if (half_q) begin
      data_d = bus_rdata;
    end else begin
      data_d = {{(DATA_W-BYTE_W){1'b0}}, bus_rdata[BYTE_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      en_q   <= 1'b0;
      half_q <= 1'b0;
      data_q <= '0;
      done_q <= 1'b0;
      eob_q  <= 1'b0;
    end else begin
      if (en_upd)  en_q   <= en_d;
      if (load_ok) half_q <= cfg_unit;
      if (capture) data_q <= data_d;
      done_q <= step;
      eob_q  <= underflow;
    end
  end

  logic [ADDR_W-1:0] raw_addr;
  assign raw_addr  = wr_phase ? side_addr[1] : side_addr[0];
  assign bus_req   = rd_phase | wr_phase;
  assign bus_we    = wr_phase;
  assign bus_half  = half_q;
  assign bus_addr  = half_q ? {raw_addr[ADDR_W-1:1], 1'b0} : raw_addr;
  assign bus_wdata = data_q;
  assign chan_en   = en_q;
  assign xfer_done = done_q;
  assign block_end = eob_q;

endmodule

// File: rtl/dma_eng_chk.sv
module dma_eng_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_load,
  input logic        xfer_req,
  input logic        chan_en,
  input logic        xfer_done,
  input logic        block_end,
  input logic        bus_req,
  input logic        bus_we,
  input logic        bus_half,
  input logic [23:0] bus_addr,
  input logic [15:0] bus_wdata,
  input logic        bus_ack
);

  // R2
  read_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !bus_we);

  // R2
  write_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && !bus_we) |=> (bus_req && bus_we));

  // R2
  release_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && bus_we) |=> (!bus_req && xfer_done));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> $stable(bus_addr));

  // R3
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && !bus_half) |-> (bus_wdata[15:8] == 8'h00));

  // R3
  half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_half) |-> !bus_addr[0]);

  // R8
  eob_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    block_end |-> (xfer_done && !chan_en));

  // R9
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_en && !bus_req) |=> !bus_req);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

endmodule

bind dma_xfer_engine dma_eng_chk u_chk (.*);

// File: tb/dma_xfer_engine_bench.sv
module dma_xfer_engine_bench;

  logic        clk;
  logic        rst_n;
  logic        cfg_load;
  logic [23:0] cfg_src_addr, cfg_dst_addr;
  logic [15:0] cfg_count;
  logic        cfg_unit;
  logic [1:0]  cfg_src_mode, cfg_dst_mode;
  logic [2:0]  cfg_src_ring, cfg_dst_ring;
  logic        xfer_req;
  logic        chan_en, xfer_done, block_end;
  logic        bus_req, bus_we, bus_half;
  logic [23:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        bus_ack;

  dma_xfer_engine u_dma_xfer_engine (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;

  function automatic logic [7:0] pat(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], 4'h5} ^ 8'hA3;
  endfunction

  // memory model: 4 KB aliased by the low address bits, acknowledge one cycle after request
  logic [7:0] mem [0:4095];
  logic [11:0] ma;
  assign ma = bus_addr[11:0];
  assign bus_rdata = bus_half ? {mem[ma | 12'h001], mem[ma & 12'hFFE]} : {8'h00, mem[ma]};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_ack <= 1'b0;
    else        bus_ack <= bus_req && !bus_ack;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 4096; k++) mem[k] <= pat(12'(k));
    end else if (bus_req && bus_ack && bus_we) begin
      if (bus_half) begin
        mem[ma & 12'hFFE] <= bus_wdata[7:0];
        mem[ma | 12'h001] <= bus_wdata[15:8];
      end else begin
        mem[ma] <= bus_wdata[7:0];
      end
    end
  end

  // bus monitor
  int          n_rd = 0, n_wr = 0;
  logic [23:0] rd_addr, wr_addr;
  logic [15:0] wr_data;
  logic        wr_half;
  always @(posedge clk) begin
    if (bus_req && bus_ack) begin
      if (bus_we) begin
        wr_addr <= bus_addr;
        wr_data <= bus_wdata;
        wr_half <= bus_half;
        n_wr    <= n_wr + 1;
      end else begin
        rd_addr <= bus_addr;
        n_rd    <= n_rd + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_addr(input logic [23:0] st, input logic [1:0] mode,
                                           input logic [2:0] rsel, input bit half, input int i);
    int idx, len, stp;
    stp = half ? 2 : 1;
    len = (rsel >= 3'd4) ? 32 : (2 << rsel);
    case (mode)
      2'b01:   idx = i;
      2'b10:   idx = i % len;
      default: idx = 0;
    endcase
    return {st[23:16], st[15:0] + 16'(idx * stp)};
  endfunction

  function automatic logic [15:0] exp_data(input logic [23:0] a, input bit half);
    logic [11:0] b;
    b = a[11:0];
    if (half) return {pat(b | 12'h001), pat(b & 12'hFFE)};
    return {8'h00, pat(b)};
  endfunction

  typedef struct packed {
    logic [23:0] src;
    logic [23:0] dst;
    logic [7:0]  n;
    logic        half;
    logic [1:0]  smode;
    logic [1:0]  dmode;
    logic [2:0]  srng;
    logic [2:0]  drng;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{24'h010100, 24'h810800, 8'd5,  1'b0, 2'b01, 2'b01, 3'd0, 3'd0},
    '{24'h020200, 24'h820800, 8'd4,  1'b1, 2'b00, 2'b01, 3'd0, 3'd0},
    '{24'h030300, 24'h830810, 8'd5,  1'b1, 2'b01, 2'b10, 3'd0, 3'd0},
    '{24'h040105, 24'h840900, 8'd10, 1'b0, 2'b10, 2'b11, 3'd2, 3'd0},
    '{24'h050400, 24'h850800, 8'd34, 1'b1, 2'b10, 2'b01, 3'd4, 3'd0},
    '{24'h060500, 24'h860820, 8'd18, 1'b0, 2'b10, 2'b10, 3'd3, 3'd1},
    '{24'h12FFFC, 24'h340840, 8'd4,  1'b1, 2'b01, 2'b01, 3'd0, 3'd0},
    '{24'h070600, 24'h870880, 8'd1,  1'b0, 2'b01, 2'b00, 3'd0, 3'd0}
  };

  task automatic program_ch(input vec_t v);
    @(negedge clk);
    cfg_src_addr = v.src;
    cfg_dst_addr = v.dst;
    cfg_count    = 16'(v.n) - 16'd1;
    cfg_unit     = v.half;
    cfg_src_mode = v.smode;
    cfg_dst_mode = v.dmode;
    cfg_src_ring = v.srng;
    cfg_dst_ring = v.drng;
    cfg_load     = 1'b1;
    @(negedge clk);
    cfg_load     = 1'b0;
  endtask

  // issue a request held for hold cycles, wait for the done pulse; returns block_end seen with it
  task automatic do_req(input int hold, output bit got, output bit eob);
    got = 0;
    eob = 0;
    @(negedge clk);
    xfer_req = 1'b1;
    repeat (hold) @(negedge clk);
    xfer_req = 1'b0;
    if (xfer_done) begin
      got = 1;
      eob = block_end;
    end
    for (int t = 0; t < 40 && !got; t++) begin
      @(negedge clk);
      if (xfer_done) begin
        got = 1;
        eob = block_end;
      end
    end
    if (!got) chk(1'b0, "R11 watchdog: no xfer_done", 0, 1);
  endtask

  initial begin
    #(4 * 190000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit got, eob;
    int rd0, dn;
    rst_n = 1'b0; cfg_load = 1'b0; xfer_req = 1'b0;
    cfg_src_addr = '0; cfg_dst_addr = '0; cfg_count = '0; cfg_unit = 1'b0;
    cfg_src_mode = '0; cfg_dst_mode = '0; cfg_src_ring = '0; cfg_dst_ring = '0;
    repeat (4) @(negedge clk);
    chk(!chan_en && !bus_req && !xfer_done && !block_end, "R1 outputs during reset",
        {chan_en, bus_req, xfer_done, block_end}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!chan_en && !bus_req && !xfer_done && !block_end, "R1 outputs after reset",
        {chan_en, bus_req, xfer_done, block_end}, 0);

    // R9: request before arming is ignored
    rd0 = n_rd;
    @(negedge clk); xfer_req = 1'b1; @(negedge clk); xfer_req = 1'b0;
    repeat (8) @(negedge clk);
    chk(n_rd == rd0 && !bus_req, "R9 request while disarmed", n_rd - rd0, 0);

    // table-driven blocks
    for (int v = 0; v < NVEC; v++) begin
      vec_t cv;
      cv = VECS[v];
      program_ch(cv);
      chk(chan_en, "R9 cfg_load arms channel", chan_en, 1);
      for (int i = 0; i < int'(cv.n); i++) begin
        logic [23:0] ea_s, ea_d;
        int r0, w0;
        r0 = n_rd; w0 = n_wr;
        do_req(1, got, eob);
        ea_s = exp_addr(cv.src, cv.smode, cv.srng, cv.half, i);
        ea_d = exp_addr(cv.dst, cv.dmode, cv.drng, cv.half, i);
        chk(n_rd == r0 + 1 && n_wr == w0 + 1 && !bus_req, "R2 one read and one write per request",
            (n_rd - r0) * 16 + (n_wr - w0), 17);
        chk(rd_addr == ea_s, "R4/R5/R6/R7 source address", rd_addr, ea_s);
        chk(wr_addr == ea_d, "R4/R5/R6/R7 destination address", wr_addr, ea_d);
        chk(wr_data == exp_data(ea_s, cv.half) && wr_half == cv.half, "R2 R3 data moved",
            {wr_half, wr_data}, {cv.half, exp_data(ea_s, cv.half)});
        chk(eob == (i == int'(cv.n) - 1), "R8 block_end with final transfer", eob, (i == int'(cv.n) - 1));
        @(negedge clk);
        chk(!xfer_done && !block_end, "R11 R8 pulses last one cycle", {xfer_done, block_end}, 0);
      end
      chk(!chan_en, "R9 channel disarmed on underflow", chan_en, 0);
      rd0 = n_rd;
      @(negedge clk); xfer_req = 1'b1; @(negedge clk); xfer_req = 1'b0;
      repeat (8) @(negedge clk);
      chk(n_rd == rd0, "R9 request after block end ignored", n_rd - rd0, 0);
    end

    // R10: request held into the read phase gives only one transfer
    program_ch('{24'h080700, 24'h880A00, 8'd3, 1'b0, 2'b01, 2'b01, 3'd0, 3'd0});
    rd0 = n_rd;
    do_req(3, got, eob);
    dn = 0;
    for (int t = 0; t < 15; t++) begin
      @(negedge clk);
      if (xfer_done) dn++;
    end
    chk(n_rd == rd0 + 1 && dn == 0, "R10 request during transfer dropped", n_rd - rd0, 1);
    chk(!eob && chan_en, "R8 no early block_end", {eob, chan_en}, 1);
    do_req(1, got, eob);
    chk(rd_addr == 24'h080701, "R5 second source address", rd_addr, 24'h080701);
    do_req(1, got, eob);
    chk(eob && !chan_en, "R8 R9 block ends after third", {eob, chan_en}, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule